// File: doc/BRIEF.md
# Power-Up Self-Diagnosis Sequencer

This block runs a built-in test of a cell-monitoring module each time the module leaves power-down. It drives each monitoring comparator (overvoltage and undervoltage per cell, plus one overtemperature comparator) and the two links arriving from the module above (fault link and status link) high and then low, one channel at a time. In each phase it checks that the observed output follows the forced level, so a channel stuck at 0 or at 1 is caught. It also folds in digital pass/fail results from the analog plausibility checks on each cell reading and from the wiring detector. From these it decides whether the configured cell count matches the wiring.

At the end of the sequence it latches a validity mask per comparator and per link, which a downstream fault aggregator uses so that healthy channels keep being monitored when others fail. It also latches one overall pass flag. The health result leaves the block as a heartbeat. After a pass the status output toggles at a fixed rate, but only while the status arriving from above keeps toggling, unless this module is the top of the stack. After a failure it stays low.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held, stim_sel is all zero, stim_level, diag_done, diag_pass and status_out are 0, and all validity outputs are 0.
- R2: A 0-to-1 change of pwr_on, seen at a clock edge, starts the test. Channels are tested in index order: cells 0..N-1 overvoltage (index c), undervoltage (N+c), overtemperature (2N), fault link (2N+1), status link (2N+2). Each channel spends SETTLE_CYC cycles forcing high, one check cycle high, SETTLE_CYC cycles forcing low and one check cycle low. stim_sel is one-hot on the channel under test and stim_level is 1 during the two high phases. One configuration cycle follows the last channel, and diag_done rises (2N+3)*(2*SETTLE_CYC+2)+1 cycles after the starting edge.
- R3: A channel whose observed output is not 1 in its high check cycle, or not 0 in its low check cycle, gets validity 0. If that channel is required, diag_pass is 0.
- R4: A cell whose in-range input is 0 during the test gets validity 0 on both its overvoltage and undervoltage channels, and diag_pass is 0.
- R5: cell_cfg 2'b00 selects N-2 cells, 2'b01 selects N-1 and 2'b11 selects N. Comparators of unselected cells are not required, get validity 0, and a fault on them has no effect on diag_pass. The check fails if a cell flagged wired lies outside the selected count, or if the code 2'b10 (which counts as N cells) is given.
- R6: The overtemperature channel is always required. The two link channels are required only when top_of_stack is 0; with top_of_stack 1 they get validity 0 and their faults do not affect diag_pass.
- R7: After a failed test (diag_done 1, diag_pass 0) status_out is held at 0.
- R8: After a passed test status_out starts at 0 and inverts every HB_HALF cycles.
- R9: When top_of_stack is 0 and status_up has not changed for 4*HB_HALF consecutive cycles in the passed state, status_out is 0. Toggling resumes in phase once status_up changes again.
- R10: pwr_on at 0 clears all validity outputs, diag_done and diag_pass by the next cycle. The validity outputs stay unchanged while pwr_on stays 1 after diag_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = operating, 0 = power-down; rising edge starts the test |
| top_of_stack | input | 1 | 1 when no module sits above this one |
| cell_cfg | input | 2 | Selected cell count code |
| cell_wired | input | NCELL | Wiring detector: cell actually connected |
| cell_in_range | input | NCELL | Plausibility checker: cell reading within limits |
| ov_cmp | input | NCELL | Overvoltage comparator outputs |
| uv_cmp | input | NCELL | Undervoltage comparator outputs |
| temp_cmp | input | 1 | Overtemperature comparator output |
| fault_up | input | 1 | Fault link from the module above |
| status_up | input | 1 | Status link from the module above |
| stim_sel | output | 2*NCELL+3 | One-hot channel currently being forced |
| stim_level | output | 1 | Level being forced on the selected channel |
| cmp_valid | output | 2*NCELL+1 | Latched validity per comparator |
| fault_up_valid | output | 1 | Latched validity of the fault link |
| status_up_valid | output | 1 | Latched validity of the status link |
| diag_done | output | 1 | Test finished |
| diag_pass | output | 1 | Test finished and passed |
| status_out | output | 1 | Heartbeat status toward the module below |

## Verification
The hardest state to reach is a passed test whose heartbeat then dies because the module above stops toggling. Reaching it needs a full clean sequence with a stimulus model whose comparators and links follow the forced level, and then a frozen upstream status for longer than two heartbeat periods. The bench models every comparator and link, with per-channel stuck-at controls, and runs an upstream heartbeat generator that it can pause and resume. It also reaches the masked-but-ignored cases: faults on unselected cells, and link faults at the top of the stack.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FHI,
      ST_CHI,
      ST_FLO,
      ST_CLO,
      ST_CFG,
      ST_PASS,
      ST_FAIL
   } diag_state_t;
endpackage

// File: rtl/sd_verdict.sv
// Derives which channels are required, which pass the plausibility test,
// and whether the cell-count selection agrees with the wiring.
module sd_verdict #(
   parameter int NCELL = 6
) (
   input  logic [1:0]         cell_cfg,
   input  logic [NCELL-1:0]   cell_wired,
   input  logic [NCELL-1:0]   cell_in_range,
   input  logic               top_of_stack,
   output logic [2*NCELL+2:0] req,
   output logic [2*NCELL+2:0] rng_ok,
   output logic               cfg_ok
);
   localparam int CW = $clog2(NCELL + 1);

   logic [CW-1:0]    sel_count;
   logic [NCELL-1:0] cell_on;

   always_comb begin
      case (cell_cfg)
         2'b00:   sel_count = CW'(NCELL - 2);
         2'b01:   sel_count = CW'(NCELL - 1);
         default: sel_count = CW'(NCELL);
      endcase
   end

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      assign cell_on[i]          = (CW'(i) < sel_count);
      assign req[i]              = cell_on[i];
      assign req[NCELL+i]        = cell_on[i];
      assign rng_ok[i]           = cell_in_range[i];
      assign rng_ok[NCELL+i]     = cell_in_range[i];
   end

   assign req[2*NCELL]      = 1'b1;
   assign req[2*NCELL+1]    = ~top_of_stack;
   assign req[2*NCELL+2]    = ~top_of_stack;
   assign rng_ok[2*NCELL]   = 1'b1;
   assign rng_ok[2*NCELL+1] = 1'b1;
   assign rng_ok[2*NCELL+2] = 1'b1;

   assign cfg_ok = (cell_cfg != 2'b10) && ((cell_wired & ~cell_on) == '0);
endmodule

// File: rtl/sd_fsm.sv
// Channel-by-channel force/check sequencer with result latching.
module sd_fsm
   import selftest_pkg::*;
#(
   parameter int NCH    = 15,
   parameter int SETTLE = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_on,
   input  logic [NCH-1:0] obs,
   input  logic [NCH-1:0] req,
   input  logic [NCH-1:0] rng_ok,
   input  logic           cfg_ok,
   output logic [NCH-1:0] stim_sel,
   output logic           stim_level,
   output logic [NCH-1:0] valid,
   output logic           done,
   output logic           pass
);
   localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int CW = $clog2(SETTLE + 1);

   diag_state_t    state;
   logic           pwr_q;
   logic [IW-1:0]  ch;
   logic [CW-1:0]  cnt;
   logic           hi_ok;
   logic [NCH-1:0] good_q;
   logic [NCH-1:0] rng_bad;
   logic [NCH-1:0] valid_q;
   logic [NCH-1:0] keep;
   logic           testing;
   logic           rise;

   assign rise    = pwr_on & ~pwr_q;
   assign testing = (state == ST_FHI) || (state == ST_CHI) ||
                    (state == ST_FLO) || (state == ST_CLO);
   assign keep    = good_q & ~rng_bad & req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pwr_q   <= 1'b0;
         ch      <= '0;
         cnt     <= '0;
         hi_ok   <= 1'b0;
         good_q  <= '0;
         rng_bad <= '0;
         valid_q <= '0;
      end else begin
         pwr_q <= pwr_on;
         if (!pwr_on) begin
            state   <= ST_IDLE;
            ch      <= '0;
            cnt     <= '0;
            hi_ok   <= 1'b0;
            good_q  <= '0;
            rng_bad <= '0;
            valid_q <= '0;
         end else begin
            if (testing) rng_bad <= rng_bad | ~rng_ok;
            unique case (state)
               ST_IDLE: if (rise) begin
                  state   <= ST_FHI;
                  ch      <= '0;
                  cnt     <= '0;
                  good_q  <= '0;
                  rng_bad <= '0;
               end
               ST_FHI: if (cnt == CW'(SETTLE - 1)) begin
                  cnt   <= '0;
                  state <= ST_CHI;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               ST_CHI: begin
                  hi_ok <= obs[ch];
                  state <= ST_FLO;
               end
               ST_FLO: if (cnt == CW'(SETTLE - 1)) begin
                  cnt   <= '0;
                  state <= ST_CLO;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               ST_CLO: begin
                  good_q[ch] <= hi_ok & ~obs[ch];
                  if (ch == IW'(NCH - 1)) begin
                     state <= ST_CFG;
                  end else begin
                     ch    <= ch + 1'b1;
                     state <= ST_FHI;
                  end
               end
               ST_CFG: begin
                  valid_q <= keep;
                  state   <= (cfg_ok && (keep == req)) ? ST_PASS : ST_FAIL;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      stim_sel = '0;
      if (testing) stim_sel[ch] = 1'b1;
   end

   assign stim_level = (state == ST_FHI) || (state == ST_CHI);
   assign valid      = valid_q;
   assign done       = (state == ST_PASS) || (state == ST_FAIL);
   assign pass       = (state == ST_PASS);

   AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && !pwr_q && state == ST_IDLE) |=> (state == ST_FHI)); // R2
   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stim_sel)); // R2
   AST_CLEAR_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> (valid_q == '0 && state == ST_IDLE)); // R10
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pwr_on) |=> $stable(valid_q)); // R10
endmodule

// File: rtl/sd_heartbeat.sv
// Heartbeat generator gated by the upstream status activity watch.
module sd_heartbeat #(
   parameter int HB_HALF = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic top_of_stack,
   input  logic status_up,
   output logic status_out
);
   localparam int TIMEOUT = 4 * HB_HALF;
   localparam int HW      = $clog2(HB_HALF);
   localparam int WW      = $clog2(TIMEOUT + 1);

   logic [HW-1:0] hb_cnt;
   logic          phase;
   logic [WW-1:0] watch;
   logic          stat_q;
   logic          alive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_cnt <= '0;
         phase  <= 1'b0;
         watch  <= '0;
         stat_q <= 1'b0;
      end else begin
         stat_q <= status_up;
         if (!run) begin
            hb_cnt <= '0;
            phase  <= 1'b0;
            watch  <= '0;
         end else begin
            if (hb_cnt == HW'(HB_HALF - 1)) begin
               hb_cnt <= '0;
               phase  <= ~phase;
            end else begin
               hb_cnt <= hb_cnt + 1'b1;
            end
            if (status_up != stat_q)
               watch <= '0;
            else if (watch < WW'(TIMEOUT))
               watch <= watch + 1'b1;
         end
      end
   end

   assign alive      = top_of_stack | (watch < WW'(TIMEOUT));
   assign status_out = run & alive & phase;

   AST_TOGGLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (phase != $past(phase))) |->
      ($past(hb_cnt) == HW'(HB_HALF - 1))); // R8
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
   parameter int NCELL      = 6,
   parameter int SETTLE_CYC = 3,
   parameter int HB_HALF    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_on,
   input  logic               top_of_stack,
   input  logic [1:0]         cell_cfg,
   input  logic [NCELL-1:0]   cell_wired,
   input  logic [NCELL-1:0]   cell_in_range,
   input  logic [NCELL-1:0]   ov_cmp,
   input  logic [NCELL-1:0]   uv_cmp,
   input  logic               temp_cmp,
   input  logic               fault_up,
   input  logic               status_up,
   output logic [2*NCELL+2:0] stim_sel,
   output logic               stim_level,
   output logic [2*NCELL:0]   cmp_valid,
   output logic               fault_up_valid,
   output logic               status_up_valid,
   output logic               diag_done,
   output logic               diag_pass,
   output logic               status_out
);
   localparam int NCH = 2 * NCELL + 3;

   if (NCELL < 3) begin : g_bad_cells
      $error("selftest_seq: NCELL must be at least 3");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("selftest_seq: SETTLE_CYC must be at least 1");
   end
   if (HB_HALF < 2) begin : g_bad_hb
      $error("selftest_seq: HB_HALF must be at least 2");
   end

   logic [NCH-1:0] obs;
   logic [NCH-1:0] req;
   logic [NCH-1:0] rng_ok;
   logic [NCH-1:0] valid;
   logic           cfg_ok;

   assign obs = {status_up, fault_up, temp_cmp, uv_cmp, ov_cmp};

   sd_verdict #(.NCELL(NCELL)) u_verdict (
      .cell_cfg      (cell_cfg),
      .cell_wired    (cell_wired),
      .cell_in_range (cell_in_range),
      .top_of_stack  (top_of_stack),
      .req           (req),
      .rng_ok        (rng_ok),
      .cfg_ok        (cfg_ok)
   );

   sd_fsm #(.NCH(NCH), .SETTLE(SETTLE_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_on     (pwr_on),
      .obs        (obs),
      .req        (req),
      .rng_ok     (rng_ok),
      .cfg_ok     (cfg_ok),
      .stim_sel   (stim_sel),
      .stim_level (stim_level),
      .valid      (valid),
      .done       (diag_done),
      .pass       (diag_pass)
   );

   sd_heartbeat #(.HB_HALF(HB_HALF)) u_hb (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (diag_pass),
      .top_of_stack (top_of_stack),
      .status_up    (status_up),
      .status_out   (status_out)
   );

   assign cmp_valid       = valid[2*NCELL:0];
   assign fault_up_valid  = valid[2*NCELL+1];
   assign status_up_valid = valid[2*NCELL+2];

   AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_done && !diag_pass) |-> !status_out); // R7
   AST_PASS_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
      diag_pass |-> cmp_valid[2*NCELL]); // R3
endmodule

// File: tb/selftest_seq_test.sv
module selftest_seq_test;
   localparam int N   = 6;
   localparam int S   = 3;
   localparam int H   = 16;
   localparam int NCH = 2 * N + 3;
   localparam int P   = 2 * S + 2;
   localparam int DUR = NCH * P + 1;
   localparam int TO  = 4 * H;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           pwr_on = 1'b0;
   logic           top = 1'b0;
   logic [1:0]     cfg = 2'b11;
   logic [N-1:0]   wired = '1;
   logic [N-1:0]   rng = '1;
   logic [NCH-1:0] s0 = '0;
   logic [NCH-1:0] s1 = '0;
   logic           hb_en = 1'b0;
   logic           hb_src = 1'b0;

   logic [NCH-1:0] obs_m;
   logic [N-1:0]   ov_cmp, uv_cmp;
   logic           temp_cmp, fault_up, status_up;
   logic [NCH-1:0] stim_sel;
   logic           stim_level;
   logic [2*N:0]   cmp_valid;
   logic           fault_up_valid, status_up_valid, diag_done, diag_pass, status_out;

   always_comb begin
      for (int c = 0; c < NCH; c++)
         obs_m[c] = s0[c] ? 1'b0 : (s1[c] ? 1'b1 : (stim_sel[c] & stim_level));
   end
   assign ov_cmp    = obs_m[N-1:0];
   assign uv_cmp    = obs_m[2*N-1:N];
   assign temp_cmp  = obs_m[2*N];
   assign fault_up  = obs_m[2*N+1];
   assign status_up = (|stim_sel) ? obs_m[2*N+2] : hb_src;

   selftest_seq uut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .top_of_stack(top),
      .cell_cfg(cfg), .cell_wired(wired), .cell_in_range(rng),
      .ov_cmp(ov_cmp), .uv_cmp(uv_cmp), .temp_cmp(temp_cmp),
      .fault_up(fault_up), .status_up(status_up),
      .stim_sel(stim_sel), .stim_level(stim_level), .cmp_valid(cmp_valid),
      .fault_up_valid(fault_up_valid), .status_up_valid(status_up_valid),
      .diag_done(diag_done), .diag_pass(diag_pass), .status_out(status_out)
   );

   int    errors = 0;
   int    checks = 0;
   string tag = "R1";
   bit    started = 0;
   bit    finished = 0;

   // expected results of the current run
   bit             e_pass;
   logic [NCH-1:0] e_mask;

   task automatic chk(string rq, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic compute_expect();
      int  cnt;
      bit  ok, allreq, rq, rk, gd;
      cnt = (cfg == 2'b00) ? N - 2 : (cfg == 2'b01) ? N - 1 : N;
      ok  = (cfg != 2'b10);
      for (int i = 0; i < N; i++) if (wired[i] && i >= cnt) ok = 0;
      allreq = 1;
      for (int c = 0; c < NCH; c++) begin
         if (c < N)            rq = (c < cnt);
         else if (c < 2 * N)   rq = ((c - N) < cnt);
         else if (c == 2 * N)  rq = 1;
         else                  rq = !top;
         rk = (c < 2 * N) ? rng[c % N] : 1'b1;
         gd = !s0[c] && !s1[c];
         e_mask[c] = rq && rk && gd;
         if (rq && !e_mask[c]) allreq = 0;
      end
      e_pass = ok && allreq;
   endtask

   // behavioural reference: time since start, heartbeat age, upstream quiet time
   int t = -1, u = 0, w = 0;
   bit pq = 0, su_q = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         t = -1; u = 0; w = 0;
      end else if (!pwr_on) begin
         t = -1;
      end else if (t < 0) begin
         if (!pq) t = 0;
      end else if (t < DUR) begin
         t = t + 1;
         if (t == DUR) begin u = 0; w = 0; end
      end else begin
         u = u + 1;
         if (status_up != su_q) w = 0;
         else if (w < TO) w = w + 1;
      end
      pq   = rst_n ? pwr_on : 1'b0;
      su_q = status_up;
   end

   always @(negedge clk) begin
      if (started && !finished) begin
         logic [NCH-1:0] esel;
         bit elvl, edone, epass, estat;
         esel = '0; elvl = 0;
         if (t >= 0 && t < NCH * P) begin
            esel[t / P] = 1'b1;
            elvl = ((t % P) <= S);
         end
         edone = (t == DUR);
         epass = edone && e_pass;
         estat = epass && (top || w < TO) && (((u / H) % 2) == 1);
         chk("R2", "stim_sel", stim_sel, esel);
         chk("R2", "stim_level", stim_level, elvl);
         chk("R2", "diag_done", diag_done, edone);
         chk(tag, "diag_pass", diag_pass, epass);
         chk(tag, "valid", {status_up_valid, fault_up_valid, cmp_valid}, edone ? e_mask : '0);
         chk(tag, "status_out", status_out, estat);
      end
   end

   initial begin
      forever begin
         repeat (H) @(posedge clk);
         #1;
         if (hb_en) hb_src = ~hb_src;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic run_diag(int extra);
      pwr_on = 1'b0;
      cyc(3);
      compute_expect();
      pwr_on = 1'b1;
      cyc(DUR + extra);
   endtask

   task automatic clear_faults();
      s0 = '0; s1 = '0; rng = '1; wired = '1; cfg = 2'b11; top = 1'b0;
   endtask

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      compute_expect();
      cyc(3);
      // R1 reset state
      chk("R1", "stim_sel", stim_sel, 0);
      chk("R1", "stim_level", stim_level, 0);
      chk("R1", "diag_done", diag_done, 0);
      chk("R1", "diag_pass", diag_pass, 0);
      chk("R1", "valid", {status_up_valid, fault_up_valid, cmp_valid}, 0);
      chk("R1", "status_out", status_out, 0);
      rst_n = 1'b1;
      started = 1;
      cyc(2);

      // R8 clean pass with live upstream heartbeat
      tag = "R8"; hb_en = 1'b1; clear_faults();
      run_diag(200);
      chk("R8", "pass after clean run", diag_pass, 1);

      // R9 upstream goes quiet, then resumes
      tag = "R9"; hb_en = 1'b0;
      cyc(150);
      chk("R9", "status quiet upstream", status_out, 0);
      hb_en = 1'b1;
      cyc(100);

      // R10 power-down clears results
      tag = "R10"; pwr_on = 1'b0;
      cyc(2);
      chk("R10", "valid cleared", {status_up_valid, fault_up_valid, cmp_valid}, 0);
      chk("R10", "done cleared", diag_done, 0);

      // R3 and R7: stuck-at-0 overvoltage cell 2
      tag = "R3 R7"; clear_faults(); s0[2] = 1'b1;
      run_diag(60);
      chk("R3", "ov2 stuck low valid", cmp_valid[2], 0);
      chk("R7", "status after fail", status_out, 0);

      // R3: stuck-at-1 undervoltage cell 0
      tag = "R3"; clear_faults(); s1[N] = 1'b1;
      run_diag(40);
      chk("R3", "uv0 stuck high pass", diag_pass, 0);

      // R4: cell 3 reading implausible
      tag = "R4"; clear_faults(); rng[3] = 1'b0;
      run_diag(40);
      chk("R4", "cell3 ov/uv valid", {cmp_valid[N+3], cmp_valid[3]}, 0);

      // R5: four-cell selection, top two unwired, fault on an unused comparator ignored
      tag = "R5"; clear_faults(); cfg = 2'b00; wired = 6'b001111; s1[5] = 1'b1;
      run_diag(80);
      chk("R5", "four-cell pass", diag_pass, 1);
      chk("R5", "unused cells valid", {cmp_valid[N+5], cmp_valid[N+4], cmp_valid[5], cmp_valid[4]}, 0);

      // R5: five-cell selection with six wired
      tag = "R5"; clear_faults(); cfg = 2'b01;
      run_diag(30);
      chk("R5", "miswired fail", diag_pass, 0);

      // R5: reserved code
      tag = "R5"; clear_faults(); cfg = 2'b10;
      run_diag(30);
      chk("R5", "reserved code fail", diag_pass, 0);

      // R6: top of stack, quiet upstream, broken fault link ignored
      tag = "R6"; clear_faults(); top = 1'b1; hb_en = 1'b0; s0[2*N+1] = 1'b1;
      run_diag(150);
      chk("R6", "top pass", diag_pass, 1);
      chk("R6", "links not valid", {status_up_valid, fault_up_valid}, 0);

      // R6: not top, fault link stuck high
      tag = "R6"; clear_faults(); hb_en = 1'b1; s1[2*N+1] = 1'b1;
      run_diag(40);
      chk("R6", "link fault fail", diag_pass, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule